// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block is the status and control word for one downstream port of a USB host controller root hub. Software reads it to see the live port state: attachment, enable, suspend, over-current, reset in progress, power and device speed. Software writes it to issue commands. The write and read meanings of the low bits differ. A 1 written to a bit triggers a set or clear action on some port state. The bit read back at that position shows a different status.

Five change flags sit in the upper half of the word. Each flag latches a port event and stays set until software writes a 1 to it. The port side supplies the connect, over-current and low-speed levels. It also signals when an external timer finishes a reset or a resume. The register drives the enable, suspend, resume, reset and power controls of the port. Line signalling and the reset and resume timers are outside this block.

Top module: `rh_port_reg`

## Requirements
- R1: After the asynchronous reset, every control output is 0 and the read word is all zeros.
- R2: Read bit 0 shows the connect level and read bit 3 shows the over-current level, each sampled one clock earlier. Read bit 9 shows the low-speed level, sampled the same way. Writing 1 to bit 0 clears enable and sets no change flag.
- R3: Writing 1 to bit 1 sets enable only while read bit 0 is 1; with no device the write has no effect. Read bit 1 equals port_enable_o.
- R4: Writing 1 to bit 2 sets suspend only while connected. Writing 1 to bit 3 while suspended raises port_resume_o, and suspend stays 1. When resume_done_i arrives during a resume, suspend and resume clear and flag bit 18 sets. Writing 1 to bit 3 while not suspended has no effect.
- R5: Writing 1 to bit 4 starts a port reset, shown on bit 4 and port_reset_o. When reset_done_i arrives during a reset, the reset clears, enable sets and flag bit 20 sets. reset_done_i outside a reset is ignored.
- R6: Writing 1 to bit 8 sets port power and writing 1 to bit 9 clears it. If both bits are written together, the clear wins. Read bit 8 equals port_power_o.
- R7: A rising over-current level clears port power and sets flag bit 19. This takes priority over a set-power write in the same cycle.
- R8: Any change of the connect level sets flag bit 16. A disconnect clears enable, suspend and resume. If the port was enabled at the disconnect, flag bit 17 also sets.
- R9: Flags at bits 16 to 20 (connect, enable, suspend, over-current, reset) clear only when a 1 is written to that bit. A written 0 leaves a flag unchanged. If an event and its clear fall in the same cycle, the flag stays 1.
- R10: Bits 5 to 7, 10 to 15 and 21 upward always read 0, and writes to them have no effect.
- R11: When several sources act on enable in one cycle, the priority from highest to lowest is: disconnect, then reset completion, then the clear-enable write, then the set-enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | DATA_W | Write data; a 1 in a bit triggers that bit's action |
| rd_data_o | output | DATA_W | Live read word |
| connect_i | input | 1 | Device attached level |
| overcurrent_i | input | 1 | Port over-current level |
| low_speed_i | input | 1 | Low-speed device level |
| reset_done_i | input | 1 | Port reset timer finished |
| resume_done_i | input | 1 | Resume timer finished |
| port_enable_o | output | 1 | Port enabled |
| port_suspend_o | output | 1 | Port suspended |
| port_resume_o | output | 1 | Resume signalling requested |
| port_reset_o | output | 1 | Port reset in progress |
| port_power_o | output | 1 | Port power switch |

## Verification
The main collision is a port event that sets a change flag in the same cycle that software writes 1 to clear that flag. The bench forces this by toggling connect together with a clear of bit 16, and by completing a reset together with a clear of bit 20; the flag is expected to read 1 afterwards. A second collision puts reset_done_i and a clear-enable write in the same cycle, and then adds a disconnect to the same cycle; the enable outcome is checked against the stated priority. A long randomized phase then lets all five inputs and random writes overlap, and the behavioural model judges every field on every clock.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
  localparam int DATA_W_DEF = 32;
  // bit positions seen by software; read and write meanings share them
  localparam int B_CONN = 0;  // rd: connect    wr: clear enable
  localparam int B_EN   = 1;  // rd: enable     wr: set enable
  localparam int B_SUSP = 2;  // rd: suspend    wr: set suspend
  localparam int B_OC   = 3;  // rd: overcurr   wr: start resume
  localparam int B_RST  = 4;  // rd: reset      wr: start reset
  localparam int B_PWR  = 8;  // rd: power      wr: set power
  localparam int B_LS   = 9;  // rd: low speed  wr: clear power
  localparam int B_CHG  = 16;
  localparam int NUM_CHG = 5;
  // change flag order inside the flag field
  localparam int C_CONN = 0;
  localparam int C_EN   = 1;
  localparam int C_SUSP = 2;
  localparam int C_OC   = 3;
  localparam int C_RST  = 4;

  typedef struct packed {
    logic conn_edge;
    logic disc;
    logic oc_rise;
  } sense_ev_t;

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
  } port_cmd_t;
endpackage

// File: rtl/rh_port_sense.sv
module rh_port_sense
  import rh_port_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      connect_i,
  input  logic      overcurrent_i,
  input  logic      low_speed_i,
  output logic      conn_q_o,
  output logic      oc_q_o,
  output logic      ls_q_o,
  output sense_ev_t ev_o
);
  logic conn_q, oc_q, ls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
      ls_q   <= 1'b0;
    end else begin
      conn_q <= connect_i;
      oc_q   <= overcurrent_i;
      ls_q   <= low_speed_i;
    end
  end

  always_comb begin
    ev_o.conn_edge = conn_q ^ connect_i;
    ev_o.disc      = conn_q & ~connect_i;
    ev_o.oc_rise   = overcurrent_i & ~oc_q;
  end

  assign conn_q_o = conn_q;
  assign oc_q_o   = oc_q;
  assign ls_q_o   = ls_q;
endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
#(
  parameter int N_CHG = NUM_CHG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  port_cmd_t        cmd_i,
  input  sense_ev_t        ev_i,
  input  logic             conn_q_i,
  input  logic             reset_done_i,
  input  logic             resume_done_i,
  output logic             en_o,
  output logic             susp_o,
  output logic             rsm_o,
  output logic             rst_o,
  output logic             pwr_o,
  output logic [N_CHG-1:0] chg_ev_o
);
  logic en_q, susp_q, rsm_q, rst_q, pwr_q;
  logic rst_cmpl, rsm_cmpl, en_lost;

  assign rst_cmpl = rst_q & reset_done_i;
  assign rsm_cmpl = rsm_q & resume_done_i;
  assign en_lost  = ev_i.disc & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      rsm_q  <= 1'b0;
      rst_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      // enable priority: disconnect, reset done, sw clear, sw set
      if (ev_i.disc)                      en_q <= 1'b0;
      else if (rst_cmpl)                  en_q <= 1'b1;
      else if (cmd_i.clr_en)              en_q <= 1'b0;
      else if (cmd_i.set_en && conn_q_i)  en_q <= 1'b1;

      if (rst_cmpl)           rst_q <= 1'b0;
      else if (cmd_i.set_rst) rst_q <= 1'b1;

      if (ev_i.disc || rsm_cmpl) begin
        susp_q <= 1'b0;
        rsm_q  <= 1'b0;
      end else begin
        if (cmd_i.set_susp && conn_q_i && !susp_q) susp_q <= 1'b1;
        if (cmd_i.clr_susp && susp_q)              rsm_q  <= 1'b1;
      end

      if (ev_i.oc_rise || cmd_i.clr_pwr) pwr_q <= 1'b0;
      else if (cmd_i.set_pwr)            pwr_q <= 1'b1;
    end
  end

  always_comb begin
    chg_ev_o         = '0;
    chg_ev_o[C_CONN] = ev_i.conn_edge;
    chg_ev_o[C_EN]   = en_lost;
    chg_ev_o[C_SUSP] = rsm_cmpl;
    chg_ev_o[C_OC]   = ev_i.oc_rise;
    chg_ev_o[C_RST]  = rst_cmpl;
  end

  assign en_o   = en_q;
  assign susp_o = susp_q;
  assign rsm_o  = rsm_q;
  assign rst_o  = rst_q;
  assign pwr_o  = pwr_q;
endmodule

// File: rtl/rh_port_chg.sv
module rh_port_chg #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;  // event beats clear
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg
  import rh_port_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              connect_i,
  input  logic              overcurrent_i,
  input  logic              low_speed_i,
  input  logic              reset_done_i,
  input  logic              resume_done_i,
  output logic              port_enable_o,
  output logic              port_suspend_o,
  output logic              port_resume_o,
  output logic              port_reset_o,
  output logic              port_power_o
);
  localparam int CHG_W = NUM_CHG;

  logic             conn_q, oc_q, ls_q;
  sense_ev_t        ev;
  port_cmd_t        cmd;
  logic [CHG_W-1:0] chg_ev, chg_clr, chg_flag;
  logic             en, susp, rsm, rst, pwr;

  always_comb begin
    cmd.clr_en   = wr_en_i & wr_data_i[B_CONN];
    cmd.set_en   = wr_en_i & wr_data_i[B_EN];
    cmd.set_susp = wr_en_i & wr_data_i[B_SUSP];
    cmd.clr_susp = wr_en_i & wr_data_i[B_OC];
    cmd.set_rst  = wr_en_i & wr_data_i[B_RST];
    cmd.set_pwr  = wr_en_i & wr_data_i[B_PWR];
    cmd.clr_pwr  = wr_en_i & wr_data_i[B_LS];
    chg_clr      = {CHG_W{wr_en_i}} & wr_data_i[B_CHG +: CHG_W];
  end

  rh_port_sense u_sense (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .connect_i     (connect_i),
    .overcurrent_i (overcurrent_i),
    .low_speed_i   (low_speed_i),
    .conn_q_o      (conn_q),
    .oc_q_o        (oc_q),
    .ls_q_o        (ls_q),
    .ev_o          (ev)
  );

  rh_port_ctrl #(.N_CHG(CHG_W)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd),
    .ev_i          (ev),
    .conn_q_i      (conn_q),
    .reset_done_i  (reset_done_i),
    .resume_done_i (resume_done_i),
    .en_o          (en),
    .susp_o        (susp),
    .rsm_o         (rsm),
    .rst_o         (rst),
    .pwr_o         (pwr),
    .chg_ev_o      (chg_ev)
  );

  rh_port_chg #(.N(CHG_W)) u_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (chg_ev),
    .clr_i  (chg_clr),
    .flag_o (chg_flag)
  );

  always_comb begin
    rd_data_o                  = '0;
    rd_data_o[B_CONN]          = conn_q;
    rd_data_o[B_EN]            = en;
    rd_data_o[B_SUSP]          = susp;
    rd_data_o[B_OC]            = oc_q;
    rd_data_o[B_RST]           = rst;
    rd_data_o[B_PWR]           = pwr;
    rd_data_o[B_LS]            = ls_q;
    rd_data_o[B_CHG +: CHG_W]  = chg_flag;
  end

  assign port_enable_o  = en;
  assign port_suspend_o = susp;
  assign port_resume_o  = rsm;
  assign port_reset_o   = rst;
  assign port_power_o   = pwr;
endmodule

// File: rtl/rh_port_reg_chk.sv
module rh_port_reg_chk
  import rh_port_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              connect_i,
  input logic              overcurrent_i,
  input logic              low_speed_i,
  input logic              reset_done_i,
  input logic              resume_done_i,
  input logic              port_enable_o,
  input logic              port_suspend_o,
  input logic              port_resume_o,
  input logic              port_reset_o,
  input logic              port_power_o
);
  p_no_conn_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[B_CONN] && !port_enable_o && !port_reset_o) |=> !port_enable_o);

  p_resume_in_susp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_resume_o |-> port_suspend_o);

  p_reset_cmpl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_reset_o && reset_done_i && !(rd_data_o[B_CONN] && !connect_i))
    |=> (!port_reset_o && port_enable_o && rd_data_o[B_CHG + C_RST]));

  p_oc_pwr_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overcurrent_i && !rd_data_o[B_OC])
    |=> (!port_power_o && rd_data_o[B_CHG + C_OC]));

  p_disc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_CONN] && !connect_i)
    |=> (!port_enable_o && !port_suspend_o && !port_resume_o && rd_data_o[B_CHG + C_CONN]));

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[B_CHG + C_CONN] && !(wr_en_i && wr_data_i[B_CHG + C_CONN]))
    |=> rd_data_o[B_CHG + C_CONN]);
endmodule

bind rh_port_reg rh_port_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rh_port_reg_test.sv
module rh_port_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        connect = 1'b0, oc = 1'b0, ls = 1'b0, rdone = 1'b0, sdone = 1'b0;
  logic        en_o, susp_o, rsm_o, rst_o, pwr_o;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0, live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rh_port_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .connect_i(connect), .overcurrent_i(oc),
    .low_speed_i(ls), .reset_done_i(rdone), .resume_done_i(sdone),
    .port_enable_o(en_o), .port_suspend_o(susp_o), .port_resume_o(rsm_o),
    .port_reset_o(rst_o), .port_power_o(pwr_o)
  );

  // behavioural reference
  bit m_conn, m_oc, m_ls, m_en, m_susp, m_rsm, m_rst, m_pwr;
  bit [4:0] m_chg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_conn, m_oc, m_ls, m_en, m_susp, m_rsm, m_rst, m_pwr} = '0;
      m_chg = '0;
    end else begin
      bit disc, cedge, orise, rc, sc, lost;
      bit [4:0] ev;
      disc  = m_conn && !connect;
      cedge = m_conn != connect;
      orise = oc && !m_oc;
      rc    = m_rst && rdone;
      sc    = m_rsm && sdone;
      lost  = disc && m_en;
      ev    = {rc, orise, sc, lost, cedge};
      for (int i = 0; i < 5; i++)
        if (ev[i]) m_chg[i] = 1'b1;
        else if (wr_en && wr_data[16+i]) m_chg[i] = 1'b0;
      if (disc) m_en = 0;
      else if (rc) m_en = 1;
      else if (wr_en && wr_data[0]) m_en = 0;
      else if (wr_en && wr_data[1] && m_conn) m_en = 1;
      if (rc) m_rst = 0; else if (wr_en && wr_data[4]) m_rst = 1;
      if (disc || sc) begin m_susp = 0; m_rsm = 0; end
      else begin
        bit was_susp;
        was_susp = m_susp;
        if (wr_en && wr_data[2] && m_conn) m_susp = 1;
        if (wr_en && wr_data[3] && was_susp) m_rsm = 1;
      end
      if (orise || (wr_en && wr_data[9])) m_pwr = 0;
      else if (wr_en && wr_data[8]) m_pwr = 1;
      m_conn = connect; m_oc = oc; m_ls = ls;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R2 connect", 32'(rd_data[0]), 32'(m_conn));
    chk("R2 overcurrent", 32'(rd_data[3]), 32'(m_oc));
    chk("R2 low speed", 32'(rd_data[9]), 32'(m_ls));
    chk("R3/R11 enable", {30'd0, rd_data[1], en_o}, {30'd0, m_en, m_en});
    chk("R4 suspend", {30'd0, rd_data[2], susp_o}, {30'd0, m_susp, m_susp});
    chk("R4 resume", 32'(rsm_o), 32'(m_rsm));
    chk("R5 reset", {30'd0, rd_data[4], rst_o}, {30'd0, m_rst, m_rst});
    chk("R6/R7 power", {30'd0, rd_data[8], pwr_o}, {30'd0, m_pwr, m_pwr});
    chk("R8/R9 flags", 32'(rd_data[20:16]), 32'(m_chg));
    chk("R10 unused", rd_data & ~32'h001F_031F, 32'd0);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= MAX_CYCLES && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, MAX_CYCLES);
      summary();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  initial begin
    tick(2);
    chk("R1 reset word", rd_data, 32'd0);
    chk("R1 reset outputs", {27'd0, en_o, susp_o, rsm_o, rst_o, pwr_o}, 32'd0);
    rst_n = 1; live = 1;
    tick(2);
    // R3: set enable with no device is ignored
    wr(32'h0000_0002);
    chk("R3 no device", 32'(en_o), 32'd0);
    // R6: power on, then both set and clear -> off
    wr(32'h0000_0100);
    chk("R6 power on", 32'(pwr_o), 32'd1);
    wr(32'h0000_0300);
    chk("R6 clear wins", 32'(pwr_o), 32'd0);
    wr(32'h0000_0100);
    // R8: connect sets flag 16
    @(negedge clk); connect = 1; ls = 1;
    tick(1);
    chk("R8 connect flag", 32'(rd_data[16]), 32'd1);
    wr(32'h0001_0000);
    chk("R9 flag cleared", 32'(rd_data[16]), 32'd0);
    wr(32'h0000_0002);
    chk("R3 enable set", 32'(en_o), 32'd1);
    wr(32'h0000_0001);
    chk("R2 clear enable", {31'd0, en_o}, 32'd0);
    // R5: reset with completion
    wr(32'h0000_0010);
    chk("R5 reset running", 32'(rst_o), 32'd1);
    tick(3);
    @(negedge clk); rdone = 1; @(negedge clk); rdone = 0;
    chk("R5 reset done", {30'd0, en_o, rd_data[20]}, 32'd3);
    // R4: suspend then resume
    wr(32'h0000_0004);
    wr(32'h0000_0008);
    chk("R4 resume started", {30'd0, susp_o, rsm_o}, 32'd3);
    tick(2);
    @(negedge clk); sdone = 1; @(negedge clk); sdone = 0;
    chk("R4 resume done", {30'd0, susp_o, rd_data[18]}, 32'd1);
    // R7: over-current beats set-power
    @(negedge clk); oc = 1; wr_en = 1; wr_data = 32'h0000_0100;
    @(negedge clk); wr_en = 0; wr_data = '0;
    chk("R7 overcurrent", {30'd0, pwr_o, rd_data[19]}, 32'd1);
    @(negedge clk); oc = 0;
    // R9 collision: reset completion with clear of flag 20
    wr(32'h001F_0010);
    @(negedge clk); rdone = 1; wr_en = 1; wr_data = 32'h0010_0001;
    @(negedge clk); rdone = 0; wr_en = 0; wr_data = '0;
    chk("R9 event beats clear", 32'(rd_data[20]), 32'd1);
    chk("R11 reset done beats clear", 32'(en_o), 32'd1);
    // R8/R11: disconnect with reset completion, flag clear of 16
    wr(32'h0000_0010);
    @(negedge clk); connect = 0; rdone = 1; wr_en = 1; wr_data = 32'h0001_0000;
    @(negedge clk); rdone = 0; wr_en = 0; wr_data = '0;
    chk("R11 disconnect wins", 32'(en_o), 32'd0);
    chk("R8 flags", 32'(rd_data[17:16]), 32'd3);
    // R10: unused bits
    wr(32'hFFE0_FCE0);
    chk("R10 ignored", rd_data & ~32'h001F_031F, 32'd0);
    // random overlap phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) connect = ~connect;
      if ($urandom_range(0, 31) == 0) oc = ~oc;
      if ($urandom_range(0, 15) == 0) ls = ~ls;
      rdone = ($urandom_range(0, 7) == 0);
      sdone = ($urandom_range(0, 7) == 0);
      wr_en = ($urandom_range(0, 2) == 0);
      wr_data = $urandom();
    end
    @(negedge clk); wr_en = 0; rdone = 0; sdone = 0;
    tick(3);
    done = 1;
    summary();
  end
endmodule